// File: doc/BRIEF.md
# Trigger and Strobe Pulse Sequencer

This block turns single-cycle trigger and test-pulse commands into timed strobe and pulse windows for a pixel matrix. An external trigger command, once accepted, opens a strobe window after a programmable delay of up to seven cycles. A test-pulse command opens a pulse window of programmable length. When that option is enabled, the pulse is followed by an automatic strobe after a programmable delay. A free-running internal sequencer can also produce periodic strobes, separated by a programmable low gap.

The strobe window can be retriggered. A start that arrives while the window is open reloads the full programmed duration, and a sticky flag records that the frame was extended. Two wrapping counters are provided. One counts triggers from all sources. The other counts the strobe windows actually opened. The busy input is active-low. When busy monitoring is enabled, external triggers that arrive while busy is asserted are dropped.

Top module: `strobe_seq`

## Requirements
- R1: After a synchronous reset, strobe_o, pulse_o and frame_ext_o are 0, and both counters are 0.
- R2: A strobe window that is not extended stays high for cfg_strobe_len_i+1 cycles. It rises in the cycle after the edge that starts it.
- R3: An accepted external trigger sampled at edge N starts the strobe at edge N+cfg_trig_delay_i. With a delay of 0, strobe_o is high right after edge N.
- R4: With cfg_busy_mon_i=1, a trigger command sampled while busy_n_i=0 is dropped: no strobe, and no count. With cfg_busy_mon_i=0, busy_n_i has no effect.
- R5: A start that arrives while strobe_o is high reloads the window, so strobe_o stays high for cfg_strobe_len_i+1 cycles after that edge. It also sets frame_ext_o, and it does not increment strobe_count_o.
- R6: A start that arrives while strobe_o is low clears frame_ext_o.
- R7: A pulse command with cfg_pulse_len_i=n>0 drives pulse_o high for exactly n cycles, starting after the sampling edge. With n=0, pulse_o stays low.
- R8: With cfg_auto_strobe_i=1, a produced pulse is followed by a strobe that rises cfg_p2s_delay_i+1 cycles after pulse_o rises.
- R9: With cfg_auto_seq_i=1, the sequencer keeps strobe_o low for cfg_gap_len_i+1 cycles and then opens a window. The first window opens cfg_gap_len_i+1 cycles after enabling.
- R10: trig_count_o increments once for every accepted external trigger, every sequencer strobe and every automatic post-pulse strobe. strobe_count_o increments once for every window opened. Both are CNT_W bits wide (16 by default) and wrap on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_cmd_i | input | 1 | External trigger command, one-cycle pulse |
| pulse_cmd_i | input | 1 | Test-pulse command, one-cycle pulse |
| busy_n_i | input | 1 | Busy, asserted low |
| cfg_strobe_len_i | input | LEN_W | Strobe length setting n (n+1 cycles high) |
| cfg_gap_len_i | input | LEN_W | Sequencer gap setting n (n+1 cycles low) |
| cfg_p2s_delay_i | input | LEN_W | Pulse-to-strobe delay setting n (n+1 cycles) |
| cfg_pulse_len_i | input | LEN_W | Pulse length in cycles, 0 disables the pulse |
| cfg_trig_delay_i | input | DLY_W | Extra cycles between a trigger and its strobe |
| cfg_busy_mon_i | input | 1 | Enables trigger rejection while busy |
| cfg_auto_seq_i | input | 1 | Enables the periodic internal sequencer |
| cfg_auto_strobe_i | input | 1 | Enables an automatic strobe after each pulse |
| strobe_o | output | 1 | Strobe window |
| pulse_o | output | 1 | Pulse window |
| frame_ext_o | output | 1 | Set when the current window was extended |
| trig_count_o | output | CNT_W | Trigger counter |
| strobe_count_o | output | CNT_W | Strobe window counter |

## Verification
The scoreboard predicts the rise cycle and the high time of every strobe window. These windows come from isolated triggers, delayed triggers, overlapping trigger pairs, pulse-driven auto strobes and a periodic sequencer run. Comparing exact rise cycles separates the trigger-delay path, the pulse-delay path and the gap timing from one another. The overlapping pair separates a proper reload from a window that ignores the second start or one that opens twice. Busy-low triggers, with monitoring on and then off, show whether rejection depends on the enable. A run of several hundred triggers carries the counters through a wrap.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;
    // Sources that can open a strobe window in one cycle
    typedef struct packed {
        logic ext;    // delayed external trigger
        logic seq;    // periodic sequencer
        logic pls;    // automatic strobe after a pulse
    } start_src_t;
endpackage

// File: rtl/ss_trig_gate.sv
module ss_trig_gate #(
    parameter int unsigned DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_cmd_i,
    input  logic             busy_n_i,
    input  logic             busy_mon_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             accept_o,
    output logic             start_o
);
    localparam int unsigned DEPTH = (1 << DLY_W) - 1;

    typedef struct packed {
        logic [DEPTH-1:0] line;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        accept_o     = trig_cmd_i && !(busy_mon_i && !busy_n_i);
        st_d.line    = (st_q.line << 1) | DEPTH'(accept_o);
        if (dly_i == '0)
            start_o = accept_o;
        else
            start_o = st_q.line[dly_i - 1'b1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/ss_pulse_gen.sv
module ss_pulse_gen #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_cmd_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [LEN_W-1:0] p2s_dly_i,
    input  logic             auto_en_i,
    output logic             pulse_o,
    output logic             fire_o
);
    typedef struct packed {
        logic             pulse;
        logic [LEN_W-1:0] pcnt;
        logic             armed;
        logic [LEN_W-1:0] dcnt;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = st_q.armed && (st_q.dcnt == '0) && auto_en_i;
        // pulse window
        if (pulse_cmd_i && (len_i != '0)) begin
            st_d.pulse = 1'b1;
            st_d.pcnt  = len_i - 1'b1;
        end else if (st_q.pulse) begin
            if (st_q.pcnt == '0) st_d.pulse = 1'b0;
            else                 st_d.pcnt  = st_q.pcnt - 1'b1;
        end
        // delay towards the automatic strobe
        if (pulse_cmd_i && (len_i != '0) && auto_en_i) begin
            st_d.armed = 1'b1;
            st_d.dcnt  = p2s_dly_i;
        end else if (st_q.armed) begin
            if (st_q.dcnt == '0) st_d.armed = 1'b0;
            else                 st_d.dcnt  = st_q.dcnt - 1'b1;
        end
    end

    assign pulse_o = st_q.pulse;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/ss_period_seq.sv
module ss_period_seq #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [LEN_W-1:0] gap_i,
    input  logic             strobe_i,
    output logic             fire_o
);
    typedef struct packed {
        logic [LEN_W-1:0] gcnt;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = en_i && !strobe_i && (st_q.gcnt >= gap_i);
        if (!en_i || strobe_i || fire_o) st_d.gcnt = '0;
        else                             st_d.gcnt = st_q.gcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/ss_strobe_win.sv
module ss_strobe_win #(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             strobe_o,
    output logic             frame_ext_o,
    output logic [CNT_W-1:0] strobe_cnt_o
);
    typedef struct packed {
        logic             strobe;
        logic [LEN_W-1:0] left;
        logic             fext;
        logic [CNT_W-1:0] scnt;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            if (st_q.strobe) begin
                st_d.fext = 1'b1;
            end else begin
                st_d.fext = 1'b0;
                st_d.scnt = st_q.scnt + 1'b1;
            end
            st_d.strobe = 1'b1;
            st_d.left   = len_i;
        end else if (st_q.strobe) begin
            if (st_q.left == '0) st_d.strobe = 1'b0;
            else                 st_d.left   = st_q.left - 1'b1;
        end
    end

    assign strobe_o     = st_q.strobe;
    assign frame_ext_o  = st_q.fext;
    assign strobe_cnt_o = st_q.scnt;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
    import strobe_seq_pkg::*;
#(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_cmd_i,
    input  logic             pulse_cmd_i,
    input  logic             busy_n_i,
    input  logic [LEN_W-1:0] cfg_strobe_len_i,
    input  logic [LEN_W-1:0] cfg_gap_len_i,
    input  logic [LEN_W-1:0] cfg_p2s_delay_i,
    input  logic [LEN_W-1:0] cfg_pulse_len_i,
    input  logic [DLY_W-1:0] cfg_trig_delay_i,
    input  logic             cfg_busy_mon_i,
    input  logic             cfg_auto_seq_i,
    input  logic             cfg_auto_strobe_i,
    output logic             strobe_o,
    output logic             pulse_o,
    output logic             frame_ext_o,
    output logic [CNT_W-1:0] trig_count_o,
    output logic [CNT_W-1:0] strobe_count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] tcnt;
    } top_st_t;

    top_st_t    st_d, st_q;
    start_src_t src;
    logic       ext_accept;
    logic       win_start;

    ss_trig_gate #(.DLY_W(DLY_W)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .trig_cmd_i (trig_cmd_i),
        .busy_n_i   (busy_n_i),
        .busy_mon_i (cfg_busy_mon_i),
        .dly_i      (cfg_trig_delay_i),
        .accept_o   (ext_accept),
        .start_o    (src.ext)
    );

    ss_pulse_gen #(.LEN_W(LEN_W)) u_pulse (
        .clk         (clk),
        .rst         (rst),
        .pulse_cmd_i (pulse_cmd_i),
        .len_i       (cfg_pulse_len_i),
        .p2s_dly_i   (cfg_p2s_delay_i),
        .auto_en_i   (cfg_auto_strobe_i),
        .pulse_o     (pulse_o),
        .fire_o      (src.pls)
    );

    ss_period_seq #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .en_i     (cfg_auto_seq_i),
        .gap_i    (cfg_gap_len_i),
        .strobe_i (strobe_o),
        .fire_o   (src.seq)
    );

    ss_strobe_win #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_win (
        .clk          (clk),
        .rst          (rst),
        .start_i      (win_start),
        .len_i        (cfg_strobe_len_i),
        .strobe_o     (strobe_o),
        .frame_ext_o  (frame_ext_o),
        .strobe_cnt_o (strobe_count_o)
    );

    always_comb begin
        win_start = src.ext || src.seq || src.pls;
        st_d.tcnt = st_q.tcnt + CNT_W'(ext_accept) + CNT_W'(src.seq) + CNT_W'(src.pls);
    end

    assign trig_count_o = st_q.tcnt;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/strobe_seq_chk.sv
module strobe_seq_chk #(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             trig_cmd_i,
    input logic             busy_n_i,
    input logic             cfg_busy_mon_i,
    input logic             cfg_auto_seq_i,
    input logic             cfg_auto_strobe_i,
    input logic [LEN_W-1:0] cfg_pulse_len_i,
    input logic             strobe_o,
    input logic             pulse_o,
    input logic             frame_ext_o,
    input logic             win_start,
    input logic [CNT_W-1:0] trig_count_o,
    input logic [CNT_W-1:0] strobe_count_o
);
    // R10
    strb_cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_o) |-> strobe_count_o == CNT_W'($past(strobe_count_o) + 1'b1));

    // R5
    strb_cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(strobe_o) |-> $stable(strobe_count_o));

    // R2
    strb_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_o) |-> $past(win_start));

    // R5
    ext_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && win_start) |=> frame_ext_o);

    // R6
    ext_flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe_o && win_start) |=> !frame_ext_o);

    // R7
    no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!pulse_o && cfg_pulse_len_i == '0) |=> !pulse_o);

    // R4
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_cmd_i && cfg_busy_mon_i && !busy_n_i && !cfg_auto_seq_i && !cfg_auto_strobe_i)
        |=> $stable(trig_count_o));
endmodule

bind strobe_seq strobe_seq_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk               (clk),
    .rst               (rst),
    .trig_cmd_i        (trig_cmd_i),
    .busy_n_i          (busy_n_i),
    .cfg_busy_mon_i    (cfg_busy_mon_i),
    .cfg_auto_seq_i    (cfg_auto_seq_i),
    .cfg_auto_strobe_i (cfg_auto_strobe_i),
    .cfg_pulse_len_i   (cfg_pulse_len_i),
    .strobe_o          (strobe_o),
    .pulse_o           (pulse_o),
    .frame_ext_o       (frame_ext_o),
    .win_start         (win_start),
    .trig_count_o      (trig_count_o),
    .strobe_count_o    (strobe_count_o)
);

// File: tb/strobe_seq_test.sv
module strobe_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int CNT_W = 8;
    localparam int DLY_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_cmd = 1'b0, pulse_cmd = 1'b0, busy_n = 1'b1;
    logic [LEN_W-1:0] slen = '0, gap = '0, p2s = '0, plen = '0;
    logic [DLY_W-1:0] tdly = '0;
    logic busy_mon = 1'b1, auto_seq = 1'b0, auto_strobe = 1'b0;
    logic strobe, pulse, fext;
    logic [CNT_W-1:0] tcount, scount;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .DLY_W(DLY_W)) uut (
        .clk(clk), .rst(rst), .trig_cmd_i(trig_cmd), .pulse_cmd_i(pulse_cmd),
        .busy_n_i(busy_n), .cfg_strobe_len_i(slen), .cfg_gap_len_i(gap),
        .cfg_p2s_delay_i(p2s), .cfg_pulse_len_i(plen), .cfg_trig_delay_i(tdly),
        .cfg_busy_mon_i(busy_mon), .cfg_auto_seq_i(auto_seq),
        .cfg_auto_strobe_i(auto_strobe), .strobe_o(strobe), .pulse_o(pulse),
        .frame_ext_o(fext), .trig_count_o(tcount), .strobe_count_o(scount)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    int exp_trig = 0, exp_strb = 0;
    bit done = 0;

    typedef struct packed { int rise; int width; } win_t;
    win_t  exp_q[$];
    string tag_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected windows as strobe windows close
    bit prev_strobe = 0;
    int rise_at = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (strobe && !prev_strobe) rise_at = cyc;
            if (!strobe && prev_strobe) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected strobe window at cycle", rise_at, -1);
                end else begin
                    win_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rise_at == e.rise, t, "strobe rise cycle", rise_at, e.rise);
                    chk(cyc - rise_at == e.width, t, "strobe high cycles", cyc - rise_at, e.width);
                end
            end
            prev_strobe = strobe;
        end
    end

    task automatic expect_win(input int rise, input int width, input string tag);
        win_t w;
        w.rise = rise;
        w.width = width;
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    // Driver: one-cycle trigger, pushes the predicted window when accepted
    task automatic fire_trig(input bit accepted, input string tag);
        @(negedge clk);
        trig_cmd = 1'b1;
        if (accepted) expect_win(cyc + 1 + int'(tdly), int'(slen) + 1, tag);
        @(negedge clk);
        trig_cmd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_counts(input string tag);
        chk(tcount == CNT_W'(exp_trig), tag, "trigger count", tcount, CNT_W'(exp_trig));
        chk(scount == CNT_W'(exp_strb), tag, "strobe count", scount, CNT_W'(exp_strb));
    endtask

    task automatic measure_pulse(output int hi);
        hi = 0;
        @(negedge clk);
        pulse_cmd = 1'b1;
        @(negedge clk);
        pulse_cmd = 1'b0;
        if (pulse) hi++;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pulse) hi++;
        end
    endtask

    initial begin
        int hi;
        int n0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        // R1 reset state
        chk(!strobe && !pulse && !fext, "R1", "outputs after reset", {strobe, pulse, fext}, 0);
        chk_counts("R1");

        // R2 plain window of n+1 cycles
        slen = 3;
        fire_trig(1, "R2");
        exp_trig++; exp_strb++;
        wait_cyc(8);
        chk_counts("R10");

        // R3 trigger delay
        tdly = 5; slen = 0;
        fire_trig(1, "R3");
        exp_trig++; exp_strb++;
        wait_cyc(12);
        tdly = 0;

        // R5 overlapping triggers extend the window
        slen = 4;
        @(negedge clk);
        trig_cmd = 1'b1;
        n0 = cyc + 1;
        expect_win(n0, 7, "R5");
        @(negedge clk); trig_cmd = 1'b0;
        @(negedge clk); trig_cmd = 1'b1;
        @(negedge clk); trig_cmd = 1'b0;
        exp_trig += 2; exp_strb++;
        wait_cyc(10);
        chk(fext == 1'b1, "R5", "frame extended flag", fext, 1);
        chk_counts("R5");

        // R6 a fresh window clears the flag
        slen = 1;
        fire_trig(1, "R6");
        exp_trig++; exp_strb++;
        chk(fext == 1'b0, "R6", "frame extended flag after fresh start", fext, 0);
        wait_cyc(6);

        // R4 busy rejection, then busy ignored with monitoring off
        busy_n = 1'b0;
        fire_trig(0, "R4");
        wait_cyc(6);
        chk_counts("R4");
        busy_mon = 1'b0;
        fire_trig(1, "R4");
        exp_trig++; exp_strb++;
        wait_cyc(6);
        chk_counts("R4");
        busy_n = 1'b1; busy_mon = 1'b1;

        // R7 pulse length and the zero setting
        plen = 3;
        measure_pulse(hi);
        chk(hi == 3, "R7", "pulse high cycles", hi, 3);
        plen = 0;
        measure_pulse(hi);
        chk(hi == 0, "R7", "pulse high cycles with zero length", hi, 0);

        // R8 automatic strobe after pulse
        plen = 2; p2s = 2; auto_strobe = 1'b1; slen = 1;
        @(negedge clk);
        pulse_cmd = 1'b1;
        expect_win(cyc + 1 + 3, 2, "R8");
        @(negedge clk); pulse_cmd = 1'b0;
        wait_cyc(10);
        auto_strobe = 1'b0;
        exp_trig++; exp_strb++;
        chk_counts("R8");

        // R9 periodic sequencer
        slen = 1; gap = 2;
        @(negedge clk);
        auto_seq = 1'b1;
        n0 = cyc + 1;
        expect_win(n0 + 2, 2, "R9");
        expect_win(n0 + 7, 2, "R9");
        expect_win(n0 + 12, 2, "R9");
        wait_cyc(14);
        auto_seq = 1'b0;
        wait_cyc(8);
        exp_trig += 3; exp_strb += 3;
        chk_counts("R9");

        // R10 counters wrap
        slen = 0;
        for (int i = 0; i < 260; i++) fire_trig(1, "R10");
        exp_trig += 260; exp_strb += 260;
        wait_cyc(4);
        chk_counts("R10");
        chk(exp_q.size() == 0, "R2", "windows still expected", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung got %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule